// File: doc/BRIEF.md
# I2C Register-Port Slave for an 8-bit I/O Expander

This block sits between a two-wire I2C bus and the small register file of an 8-bit I/O expander. It watches SCL and SDA through a two-stage synchronizer, finds START and STOP conditions and answers to one 7-bit address. The upper four address bits are fixed at `0100` and the lower three come from strap pins. SDA is pulled low through an open-drain enable output, which is high when the block drives the line low.

A write transaction carries a command byte and then any number of data bytes. The command byte picks one of four registers: the input image (read-only), the output latch, the polarity mask and the direction mask. The chosen register stays selected after the transaction ends. Every later data byte, in the same or a following transaction, goes to it. A read transaction starts with the address and the read bit. The block then sends the selected register MSB first, repeating it for as long as the master acknowledges. The pin logic and interrupt logic sit in another block. That block supplies the input image and takes the three writable registers.

Top module: `i2cx_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal `0100` followed by the three strap pins, MSB first. The address byte's LSB is the direction: 0 for write, 1 for read.
- R2: After an address byte that does not match, the block does not acknowledge and keeps SDA released. It ignores all bytes until the next START or STOP, so no register changes.
- R3: In a write transaction the block acknowledges the command byte and every data byte. Each data byte is stored into the selected register, and no register changes at any other time.
- R4: The register selection does not auto-increment. Several data bytes in one write all land in the same register, and a read without a new command byte returns that same register.
- R5: In a read transaction the block sends the selected register MSB first, one bit per SCL clock, starting right after its address acknowledge.
- R6: When the master acknowledges a read byte, the block sends the selected register again. When the master does not acknowledge, the block releases SDA and stays silent until START or STOP.
- R7: Register 0 is read-only. Writes to it are acknowledged and change nothing. Reading it returns the `in_image` input, and each byte loaded from it pulses `in_read_pulse` for one clock.
- R8: Only the low two bits of the command byte select the register (0 input, 1 output, 2 polarity, 3 direction); higher bits are ignored.
- R9: Synchronous reset sets the direction register to 0xFF, the output and polarity registers to 0x00 and the selection to register 0. It also returns the protocol state machine to idle with SDA released.
- R10: A START at any point, including in the middle of a byte, restarts address reception. A STOP at any point returns to idle and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_pins | input | 3 | Low address bits set by board straps |
| in_image | input | 8 | Input-port value supplied by the pin logic |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| out_reg | output | 8 | Output latch register |
| pol_reg | output | 8 | Polarity inversion register |
| dir_reg | output | 8 | Direction register, 1 = input |
| in_read_pulse | output | 1 | One-clock pulse when register 0 is loaded for sending |

## Verification
The assertions check on every cycle the behaviour that shows at each clock. The registers are at their reset values after reset. No register moves without a write strobe, and a strobe aimed at register 0 leaves all registers unchanged. START and STOP always lead to the stated state with SDA released, and SDA stays released while idle or ignoring. Whole-transaction behaviour can only come from the bench's scenarios. That covers address matching against the strap pins, the non-incrementing selection across bytes and transactions, masked command values, the bit order of read data, NACK handling and recovery from a START in the middle of a byte.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } fsm_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cx_regfile.sv
module i2cx_regfile #(
  parameter int                DATA_W  = 8,
  parameter int                REG_CNT = 4,
  parameter logic [DATA_W-1:0] OUT_RST = '0,
  parameter logic [DATA_W-1:0] POL_RST = '0,
  parameter logic [DATA_W-1:0] DIR_RST = '1,
  localparam int               SEL_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] in_image,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] out_reg,
  output logic [DATA_W-1:0] pol_reg,
  output logic [DATA_W-1:0] dir_reg
);
  localparam logic [SEL_W-1:0] SEL_OUT = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_POL = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_DIR = SEL_W'(3);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_reg <= OUT_RST;
      pol_reg <= POL_RST;
      dir_reg <= DIR_RST;
    end else if (we) begin
      if (sel == SEL_OUT) out_reg <= wdata;
      if (sel == SEL_POL) pol_reg <= wdata;
      if (sel == SEL_DIR) dir_reg <= wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_OUT: rdata = out_reg;
      SEL_POL: rdata = pol_reg;
      SEL_DIR: rdata = dir_reg;
      default: rdata = in_image;
    endcase
  end
endmodule

// File: rtl/i2cx_proto.sv
module i2cx_proto
  import i2cx_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          PIN_W   = 3,
  parameter int          SEL_W   = 2,
  parameter logic [DATA_W-2-PIN_W:0] ADDR_HI = 4'b0100,
  localparam int         CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic [PIN_W-1:0]  strap_pins,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  ptr,
  output logic              rd_pulse,
  output logic              sda_low,
  output logic              start_det,
  output logic              stop_det,
  output fsm_t              state
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  fsm_t              after_ack;
  logic              master_ack;
  logic              addr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
  assign addr_hit  = (rx_sh[DATA_W-1:1] == {ADDR_HI, strap_pins});

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      after_ack  <= ST_IDLE;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      ptr        <= '0;
      sda_low    <= 1'b0;
      master_ack <= 1'b0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      rd_pulse   <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      rd_pulse <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        sda_low <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        cnt     <= '0;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[DATA_W-2:0], sda};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_low   <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= rx_sh[0] ? ST_RDATA : ST_CMD;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                if (state == ST_CMD) ptr <= rx_sh[SEL_W-1:0];
                else begin
                  wr_en   <= 1'b1;
                  wr_data <= rx_sh;
                end
                sda_low   <= 1'b1;
                state     <= ST_ACK;
                after_ack <= ST_WDATA;
              end
            end
          end
          ST_ACK, ST_RACK: begin
            if (scl_rise && state == ST_RACK) master_ack <= ~sda;
            if (scl_fall) begin
              cnt <= '0;
              if ((state == ST_ACK && after_ack == ST_RDATA) ||
                  (state == ST_RACK && master_ack)) begin
                tx_sh    <= rd_data;
                sda_low  <= ~rd_data[DATA_W-1];
                rd_pulse <= (ptr == '0);
                state    <= ST_RDATA;
              end else begin
                sda_low <= 1'b0;
                state   <= (state == ST_ACK) ? after_ack : ST_IGNORE;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_low <= 1'b0;
                cnt     <= '0;
                state   <= ST_RACK;
              end else begin
                tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                sda_low <= ~tx_sh[DATA_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cx_slave.sv
module i2cx_slave
  import i2cx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PIN_W       = 3,
  parameter int REG_CNT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [PIN_W-1:0]  strap_pins,
  input  logic [DATA_W-1:0] in_image,
  output logic              sda_drive_low,
  output logic [DATA_W-1:0] out_reg,
  output logic [DATA_W-1:0] pol_reg,
  output logic [DATA_W-1:0] dir_reg,
  output logic              in_read_pulse
);
  localparam int SEL_W = $clog2(REG_CNT);

  logic [1:0]        bus_sync;
  logic              wr_en, start_det, stop_det;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [SEL_W-1:0]  wr_sel;
  fsm_t              fsm_state;

  i2cx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (bus_sync)
  );

  i2cx_proto #(.DATA_W(DATA_W), .PIN_W(PIN_W), .SEL_W(SEL_W)) u_proto (
    .clk        (clk),
    .rst        (rst),
    .scl        (bus_sync[1]),
    .sda        (bus_sync[0]),
    .strap_pins (strap_pins),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ptr        (wr_sel),
    .rd_pulse   (in_read_pulse),
    .sda_low    (sda_drive_low),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .state      (fsm_state)
  );

  i2cx_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_en),
    .sel      (wr_sel),
    .wdata    (wr_data),
    .in_image (in_image),
    .rdata    (rd_data),
    .out_reg  (out_reg),
    .pol_reg  (pol_reg),
    .dir_reg  (dir_reg)
  );
endmodule

// File: rtl/i2cx_slave_chk.sv
module i2cx_slave_chk
  import i2cx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_drive_low,
  input logic [DATA_W-1:0] out_reg,
  input logic [DATA_W-1:0] pol_reg,
  input logic [DATA_W-1:0] dir_reg,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic              start_det,
  input logic              stop_det,
  input fsm_t              fsm_state
);
  assert_reset_defaults_R9: assert property (@(posedge clk)
    rst |=> (dir_reg == '1 && out_reg == '0 && pol_reg == '0 && !sda_drive_low));

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (rst)
    fsm_state == ST_IDLE |-> !sda_drive_low);

  assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(out_reg) && $stable(pol_reg) && $stable(dir_reg)));

  assert_input_reg_ro_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == '0) |=> ($stable(out_reg) && $stable(pol_reg) && $stable(dir_reg)));

  assert_ignore_released_R2: assert property (@(posedge clk) disable iff (rst)
    fsm_state == ST_IGNORE |-> !sda_drive_low);

  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (fsm_state == ST_ADDR && !sda_drive_low));

  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (fsm_state == ST_IDLE && !sda_drive_low));
endmodule

bind i2cx_slave i2cx_slave_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sda_drive_low (sda_drive_low),
  .out_reg       (out_reg),
  .pol_reg       (pol_reg),
  .dir_reg       (dir_reg),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .start_det     (start_det),
  .stop_det      (stop_det),
  .fsm_state     (fsm_state)
);

// File: tb/i2cx_slave_test.sv
module i2cx_slave_test;
  localparam int Q = 8;
  localparam logic [2:0] PINS   = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b0100, PINS, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b0100, PINS, 1'b1};
  localparam logic [7:0] IMAGE  = 8'h5A;
  // {command, data, expected readback}
  localparam logic [23:0] VEC [7] = '{
    {8'h01, 8'hA5, 8'hA5},
    {8'h02, 8'h3C, 8'h3C},
    {8'h03, 8'h0F, 8'h0F},
    {8'h00, 8'hFF, IMAGE},
    {8'h05, 8'h81, 8'h81},
    {8'h06, 8'h42, 8'h42},
    {8'hFF, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic drv, rd_pulse;
  logic [7:0] out_reg, pol_reg, dir_reg;
  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~drv;

  i2cx_slave uut (
    .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (sda_bus),
    .strap_pins (PINS), .in_image (IMAGE), .sda_drive_low (drv),
    .out_reg (out_reg), .pol_reg (pol_reg), .dir_reg (dir_reg),
    .in_read_pulse (rd_pulse)
  );

  always @(posedge clk) if (rd_pulse) pulses++;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick();
    sda_m = 1'b0; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b0; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b1; tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick();
      scl_m = 1'b1; tick();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    ack = ~sda_bus;
    scl_m = 1'b0; tick();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick();
      scl_m = 1'b1; tick();
      b[i] = sda_bus;
      scl_m = 1'b0;
    end
    tick();
    sda_m = ~give_ack; tick();
    scl_m = 1'b1; tick();
    scl_m = 1'b0; tick();
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] cmd, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(ADDR_W, a0);
    send_byte(cmd, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_txn(input logic [7:0] cmd, output logic [7:0] b, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(ADDR_W, a0);
    send_byte(cmd, a1);
    bus_rstart();
    send_byte(ADDR_R, a2);
    recv_byte(1'b0, b);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok, a, b0;
    logic [7:0] rb, rb2;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    tick();

    // R9: reset state
    chk("R9 dir reset", dir_reg, 8'hFF);
    chk("R9 out reset", out_reg, 8'h00);
    chk("R9 pol reset", pol_reg, 8'h00);
    chk("R9 sda released", {7'd0, drv}, 8'h00);

    // Vector walk: R1 R3 R5 R7 R8
    for (int i = 0; i < 7; i++) begin
      wr_txn(VEC[i][23:16], VEC[i][15:8], ok);
      chk("R1 R3 write acks", {7'd0, ok}, 8'h01);
      rd_txn(VEC[i][23:16], rb, ok);
      chk("R5 read acks", {7'd0, ok}, 8'h01);
      chk("R5 R7 R8 readback", rb, VEC[i][7:0]);
    end
    chk("R8 out after masked cmd", out_reg, 8'h81);
    chk("R8 pol after masked cmd", pol_reg, 8'h42);
    chk("R8 dir after masked cmd", dir_reg, 8'h00);

    // R2: address mismatch
    bus_start();
    send_byte(8'h44, a);
    chk("R2 no ack on mismatch", {7'd0, a}, 8'h00);
    send_byte(8'h01, a);
    chk("R2 no ack after mismatch", {7'd0, a}, 8'h00);
    send_byte(8'h77, a);
    chk("R2 sda released", {7'd0, drv}, 8'h00);
    bus_stop();
    chk("R2 out unchanged", out_reg, 8'h81);

    // R4: no auto-increment across data bytes
    bus_start();
    send_byte(ADDR_W, a);
    send_byte(8'h01, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, b0);
    bus_stop();
    chk("R3 R4 last data acked", {7'd0, b0}, 8'h01);
    chk("R4 out holds last byte", out_reg, 8'h33);
    chk("R4 pol untouched", pol_reg, 8'h42);
    chk("R4 dir untouched", dir_reg, 8'h00);

    // R4 R6: read without new command, ACK then NACK
    bus_start();
    send_byte(ADDR_R, a);
    recv_byte(1'b1, rb);
    recv_byte(1'b0, rb2);
    chk("R6 released after nack", {7'd0, drv}, 8'h00);
    bus_stop();
    chk("R4 first read same reg", rb, 8'h33);
    chk("R6 second read same reg", rb2, 8'h33);

    // R7: input read pulse, and write to register 0 ignored
    pulses = 0;
    rd_txn(8'h00, rb, ok);
    chk("R7 input image read", rb, IMAGE);
    chk("R7 one read pulse", pulses[7:0], 8'h01);
    wr_txn(8'h04, 8'hEE, ok);
    chk("R7 write reg0 acked", {7'd0, ok}, 8'h01);
    chk("R7 out unchanged", out_reg, 8'h33);
    chk("R7 pol unchanged", pol_reg, 8'h42);
    chk("R7 dir unchanged", dir_reg, 8'h00);

    // R10: START in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; tick();
      scl_m = 1'b1; tick();
      scl_m = 1'b0;
    end
    bus_rstart();
    send_byte(ADDR_W, a);
    send_byte(8'h02, ok);
    send_byte(8'h99, b0);
    bus_stop();
    chk("R10 write after mid-byte start", {6'd0, ok, b0}, 8'h03);
    chk("R10 pol written", pol_reg, 8'h99);

    // R10: STOP after command byte
    bus_start();
    send_byte(ADDR_W, a);
    send_byte(8'h01, a);
    bus_stop();
    chk("R10 released after stop", {7'd0, drv}, 8'h00);
    chk("R10 out unchanged", out_reg, 8'h33);
    rd_txn(8'h02, rb, ok);
    chk("R10 later read ok", rb, 8'h99);

    // R9: reset in the middle of a transaction
    bus_start();
    send_byte(ADDR_W, a);
    send_byte(8'h03, a);
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 dir after mid reset", dir_reg, 8'hFF);
    chk("R9 pol after mid reset", pol_reg, 8'h00);
    chk("R9 released after mid reset", {7'd0, drv}, 8'h00);
    scl_m = 1'b1; sda_m = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    bus_start();
    send_byte(ADDR_R, a);
    recv_byte(1'b0, rb);
    bus_stop();
    chk("R9 selection back to reg0", rb, IMAGE);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule